// File: doc/BRIEF.md
# Received Frame Length Status FIFO

This block sits in the receive path of a UART running in an infrared mode. Each time the framer finishes a frame, it presents the frame's byte count of up to 12 bits with a one-cycle completion strobe. The block queues these counts in order of arrival, so software can later match each count to the data it drained from the receive buffer. Outside the infrared modes, completion strobes are ignored.

Software reaches the queue through a small byte-wide register port. Two addresses give a non-destructive view of the oldest entry: one returns the low eight bits and the other returns the upper four bits. A third address returns queue status, and reading it retires the oldest entry. Software therefore reads both length bytes first and then the status. A fourth address holds a flush bit. Writing 1 to it empties the queue one cycle later, and the bit then clears itself.

The read data is combinational from the address during a read strobe. Every state change takes effect at the following rising clock edge.

Top module: `frame_len_fifo`

## Requirements
- R1: After synchronous reset the queue is empty. The status read returns 0x01, and the length addresses and the control address all read 0x00.
- R2: Accepted lengths come out in arrival order. Address 0 returns bits 7:0 of the oldest entry.
- R3: Address 1 returns bits 11:8 of the oldest entry in bits 3:0, with bits 7:4 reading 0.
- R4: Reading address 0 or 1 never retires an entry or changes what is read next.
- R5: Reading address 2 returns empty in bit 0, full in bit 1 and sticky overflow in bit 2, with bits 7:3 at 0. The read also retires the oldest entry when the queue is not empty.
- R6: While the queue is empty, addresses 0 and 1 read 0x00. A status read leaves the queue unchanged.
- R7: The queue holds 8 entries. When a completion strobe arrives while the queue is full, that length is dropped and the overflow flag sets and stays set.
- R8: A completion strobe and a status read in the same cycle are both carried out when the queue is neither empty nor full.
- R9: Writing address 3 with bit 7 set makes bit 7 read 1 in the next cycle. At the edge that ends that cycle, the queue and overflow flag are cleared and bit 7 returns to 0. A write with bit 7 clear has no effect. A strobe or status read during the flush cycle has no effect.
- R10: With the infrared-mode input low, completion strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ir_mode | input | 1 | High while the UART is in an infrared mode |
| frame_done | input | 1 | One-cycle strobe: a frame has completed |
| frame_len | input | 12 | Length of the completed frame |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 length low, 1 length high, 2 status, 3 control |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, 0 when no read |

## Verification
The bench first runs directed patterns.
- Filling past capacity separates a dropped push from a stored one, and shows whether overflow stays set.
- Repeated peeks followed by status reads separate a non-destructive read from a popping one.
- Draining the queue to empty exposes what the length addresses return when nothing is stored.
- A flush with readback of the control bit on two successive cycles separates the pending state from the completed flush.
- Strobes with the mode input low show whether mode gating is applied.

A long seeded random mix of strobes, peeks, pops and occasional flushes then interleaves these events at full, empty and mid-fill levels. A bench model predicts every read value in that mix.

// File: rtl/flf_pkg.sv
package flf_pkg;

    localparam int LEN_W    = 12;
    localparam int BYTE_W   = 8;
    localparam int LO_W     = 8;
    localparam int HI_W     = LEN_W - LO_W;
    localparam int FLUSH_BIT = 7;

    typedef enum logic [1:0] {
        A_LEN_LO = 2'd0,
        A_LEN_HI = 2'd1,
        A_STATUS = 2'd2,
        A_CTRL   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       ovf;
        logic       full;
        logic       empty;
    } status_t;

    function automatic logic [BYTE_W-1:0] pack_status(input logic empty,
                                                      input logic full,
                                                      input logic ovf);
        status_t s;
        s.rsvd  = '0;
        s.ovf   = ovf;
        s.full  = full;
        s.empty = empty;
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] len_lo(input logic [LEN_W-1:0] v);
        return v[LO_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] len_hi(input logic [LEN_W-1:0] v);
        return {{(BYTE_W-HI_W){1'b0}}, v[LEN_W-1:LO_W]};
    endfunction

endpackage

// File: rtl/flf_store.sv
module flf_store
    import flf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push_req,
    input  logic [LEN_W-1:0] push_len,
    input  logic             pop_req,
    output logic [LEN_W-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [LEN_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push_req && !full && !flush;
    assign do_pop  = pop_req && !empty && !flush;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_len;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push_req && full) ovf <= 1'b1;
        end
    end

    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_drop_full_r7: assert property (@(posedge clk) disable iff (rst)
        (push_req && full && !pop_req && !flush) |=> ($stable(count) && ovf));

    p_push_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !empty && !full && !flush) |=> $stable(count));

    p_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !empty && !push_req && !flush) |=> (count == $past(count) - 1'b1));

    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (empty && !ovf));
endmodule

// File: rtl/flf_regs.sv
module flf_regs
    import flf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [LEN_W-1:0]  head,
    input  logic              empty,
    input  logic              full,
    input  logic              ovf,
    output logic [BYTE_W-1:0] rdata,
    output logic              flush_q,
    output logic              pop_req
);
    reg_addr_e a;
    logic      flush_set;

    assign a         = reg_addr_e'(addr);
    assign flush_set = wr_en && (a == A_CTRL) && wdata[FLUSH_BIT];
    assign pop_req   = rd_en && (a == A_STATUS) && !flush_q;

    always_ff @(posedge clk) begin
        if (rst) flush_q <= 1'b0;
        else     flush_q <= flush_set;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (a)
                A_LEN_LO: rdata = empty ? '0 : len_lo(head);
                A_LEN_HI: rdata = empty ? '0 : len_hi(head);
                A_STATUS: rdata = pack_status(empty, full, ovf);
                A_CTRL:   rdata = BYTE_W'(flush_q) << FLUSH_BIT;
                default:  rdata = '0;
            endcase
        end
    end

    p_self_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_q && !flush_set) |=> !flush_q);

    p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && (a == A_LEN_LO || a == A_LEN_HI)) |-> (rdata == '0));

    p_hi_rsvd_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && a == A_LEN_HI) |-> (rdata[7:4] == 4'h0));
endmodule

// File: rtl/frame_len_fifo.sv
module frame_len_fifo
    import flf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ir_mode,
    input  logic              frame_done,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    logic [LEN_W-1:0] head;
    logic empty, full, ovf, flush_q, pop_req, push_req;

    assign push_req = frame_done && ir_mode && !flush_q;

    flf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush_q),
        .push_req (push_req),
        .push_len (frame_len),
        .pop_req  (pop_req),
        .head     (head),
        .empty    (empty),
        .full     (full),
        .ovf      (ovf)
    );

    flf_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .head    (head),
        .empty   (empty),
        .full    (full),
        .ovf     (ovf),
        .rdata   (rdata),
        .flush_q (flush_q),
        .pop_req (pop_req)
    );

    p_peek_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == 2'd0 || addr == 2'd1) && !frame_done && !wr_en && !flush_q)
        |=> ($stable(head) && $stable(empty)));

    p_mode_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !ir_mode && !rd_en && !flush_q) |=> ($stable(empty) && $stable(ovf)));
endmodule

// File: tb/test_frame_len_fifo.sv
module test_frame_len_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst, ir_mode, frame_done, rd_en, wr_en;
    logic [11:0] frame_len;
    logic [1:0]  addr;
    logic [7:0]  wdata, rdata;

    int checks = 0, errors = 0, cycles = 0;
    int q[$];
    bit m_ovf = 0, m_flush = 0, done = 0;

    frame_len_fifo #(.DEPTH(DEPTH)) i_frame_len_fifo (
        .clk(clk), .rst(rst), .ir_mode(ir_mode), .frame_done(frame_done),
        .frame_len(frame_len), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] expect_rd(input logic [1:0] a);
        case (a)
            2'd0: return (q.size() == 0) ? 8'h00 : q[0][7:0];
            2'd1: return (q.size() == 0) ? 8'h00 : {4'h0, q[0][11:8]};
            2'd2: return {5'b0, m_ovf, q.size() == DEPTH, q.size() == 0};
            default: return {m_flush, 7'b0};
        endcase
    endfunction

    task automatic cyc(input bit pu, input logic [11:0] len, input bit ir,
                       input bit rd, input bit wr, input logic [1:0] a,
                       input logic [7:0] wd, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        frame_done = pu; frame_len = len; ir_mode = ir;
        rd_en = rd; wr_en = wr; addr = a; wdata = wd;
        #1;
        exp = rd ? expect_rd(a) : 8'h00;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, exp);
        end
        @(posedge clk);
        if (m_flush) begin
            q.delete(); m_ovf = 0;
            m_flush = wr && a == 2'd3 && wd[7];
        end else begin
            bit was_full;
            was_full = (q.size() == DEPTH);
            if (rd && a == 2'd2 && q.size() > 0) void'(q.pop_front());
            if (pu && ir) begin
                if (was_full) m_ovf = 1;
                else q.push_back(int'(len));
            end
            m_flush = wr && a == 2'd3 && wd[7];
        end
    endtask

    task automatic idle_rd(input logic [1:0] a, input string tag);
        cyc(0, 12'h0, 1, 1, 0, a, 8'h00, tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; ir_mode = 1; frame_done = 0; frame_len = 0;
        rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        idle_rd(2'd2, "R1 status");
        idle_rd(2'd0, "R1 lo");
        idle_rd(2'd1, "R1 hi");
        idle_rd(2'd3, "R1 ctrl");
        // R6: pop on empty does nothing
        idle_rd(2'd2, "R6 pop empty");
        idle_rd(2'd0, "R6 lo empty");

        // R2/R7: fill past capacity
        for (int i = 0; i < DEPTH + 2; i++)
            cyc(1, 12'hA50 + 12'(i * 17), 1, 0, 0, 2'd0, 8'h0, "R7 fill");
        idle_rd(2'd2, "R7 full+ovf");
        // R4: repeated peeks keep the head
        for (int i = 0; i < 3; i++) begin
            idle_rd(2'd0, "R4 lo peek");
            idle_rd(2'd1, "R3 hi peek");
        end
        // R5: pop a few, check order
        for (int i = 0; i < 3; i++) begin
            idle_rd(2'd0, "R2 order lo");
            idle_rd(2'd1, "R3 order hi");
            idle_rd(2'd2, "R5 pop");
        end
        // R8: simultaneous push and pop mid-fill
        cyc(1, 12'hFED, 1, 1, 0, 2'd2, 8'h0, "R8 push+pop");
        idle_rd(2'd2, "R8 after");
        // R10: mode gate
        cyc(1, 12'h123, 0, 0, 0, 2'd0, 8'h0, "R10 gated");
        idle_rd(2'd2, "R10 status");
        // R9: write without bit 7, then flush
        cyc(0, 12'h0, 1, 0, 1, 2'd3, 8'h7F, "R9 noflush");
        idle_rd(2'd3, "R9 ctrl idle");
        idle_rd(2'd2, "R9 unchanged");
        cyc(0, 12'h0, 1, 0, 1, 2'd3, 8'h80, "R9 flush wr");
        cyc(1, 12'h3C3, 1, 1, 0, 2'd3, 8'h0, "R9 pending");
        idle_rd(2'd3, "R9 cleared");
        idle_rd(2'd2, "R9 empty");
        // drain to empty
        for (int i = 0; i < 3; i++) cyc(1, 12'(i + 5), 1, 0, 0, 2'd0, 8'h0, "R2 refill");
        for (int i = 0; i < 4; i++) idle_rd(2'd2, "R6 drain");
        idle_rd(2'd1, "R6 hi empty");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit pu, rd, wr;
            logic [1:0] a;
            r  = int'($urandom_range(0, 99));
            pu = ($urandom_range(0, 99) < 45);
            rd = (r < 70);
            a  = 2'($urandom_range(0, 3));
            wr = !rd && (r > 97);
            cyc(pu, 12'($urandom), ($urandom_range(0, 15) != 0), rd, wr,
                wr ? 2'd3 : a, wr ? 8'($urandom) : 8'h00, "R5 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule